// File: doc/BRIEF.md
# Crossbar Multi-Region Address Decoder

This block sits behind the address stage of a crossbar. It takes a captured transaction address and returns which destination port the transaction goes to and which of that port's address windows it hit. Every destination owns a fixed number of windows. Each window is set by a base address and a size in bits, and all of these are elaboration parameters. A window whose size is zero is switched off.

A window only counts when two filters also pass. The first is a security filter: a destination can be marked secure, and it then refuses non-secure accesses. The second is a connectivity filter. Reads and writes each have their own mask saying which source may reach which destination.

The result is registered. It appears one clock after the address is offered, and it holds until the next address arrives. When nothing qualifies, the block raises a decode-error flag and presents the error response code, so the crossbar can answer the transaction itself. Each window base must be aligned to its window size. A misaligned base stops elaboration.

Top module: `xbar_region_decoder`

## Requirements
- R1: A window with size `w` (1 to ADDR_W-1) matches when `addr >> w` equals `base >> w`. A window with size `w >= ADDR_W` matches every address.
- R2: A window whose size field is zero never matches, including at address equal to its base.
- R3: Window sizes below 12 bits decode correctly, so a 256-byte and a 16-byte window resolve exactly at their edges.
- R4: For a destination whose bit is set in SECURE_MASK, a candidate is refused when `in_prot[1]` is 1 (non-secure). `in_prot[0]` and `in_prot[2]` have no effect.
- R5: A candidate destination `d` for source `s` is permitted only if bit `s + d*SRC_COUNT` is set. The bit comes from READ_CONN when `in_is_write` is 0 and from WRITE_CONN when it is 1.
- R6: Among permitted matching windows, the one with the highest destination index wins, and within that destination the highest window index wins. A refused higher candidate lets a lower one win.
- R7: On a miss, `out_hit`=0, `out_decerr`=1, `out_resp`=2'b11, `out_dst`=0 and `out_region`=0. On a hit, `out_hit`=1, `out_decerr`=0 and `out_resp`=2'b00.
- R8: The result is visible, with `out_valid`=1, in the cycle after the clock edge that samples `in_valid`=1. With `in_valid`=0, `out_valid` falls to 0 and the other outputs keep their last values.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Address offered this cycle |
| in_addr | input | ADDR_W | Transaction address |
| in_prot | input | 3 | Protection field; bit 1 set means non-secure |
| in_src | input | SRC_W | Index of the requesting source |
| in_is_write | input | 1 | 1 for a write, 0 for a read |
| out_valid | output | 1 | One-cycle pulse when a new result is presented |
| out_dst | output | DST_W | Selected destination index |
| out_region | output | REG_W | Matching window index |
| out_hit | output | 1 | A permitted window matched |
| out_decerr | output | 1 | No permitted window matched |
| out_resp | output | 2 | Response code: 2'b00 on hit, 2'b11 on miss |

## Verification
The properties assume that `in_src` stays below SRC_COUNT whenever `in_valid` is high, since an out-of-range source has no mask bit. They also assume that no input changes within a clock cycle. The stimulus uses only sources 0 and 1 of the two configured. It changes inputs on the falling edge and samples results on the following falling edge. The default map deliberately overlaps a 16-byte window of destination 2 with a 256-byte window of destination 1. This lets the priority, security and connectivity filters be observed against one another.

// File: rtl/xdec_pkg.sv
package xdec_pkg;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  localparam int unsigned SIZE_FIELD_W = 8;

endpackage

// File: rtl/xdec_region_cmp.sv
module xdec_region_cmp #(
  parameter int unsigned     ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter int unsigned     BITS   = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);

  if (BITS == 0) begin : g_off
    assign hit = 1'b0;
  end else if (BITS >= ADDR_W) begin : g_all
    assign hit = 1'b1;
  end else begin : g_cmp
    localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << BITS) - ADDR_W'(1);
    if ((BASE & LOW_MASK) != '0) begin : g_misaligned
      $error("window base not aligned to its size");
    end
    assign hit = (addr[ADDR_W-1:BITS] == BASE[ADDR_W-1:BITS]);
  end

endmodule

// File: rtl/xdec_access_filter.sv
module xdec_access_filter #(
  parameter int unsigned DST_COUNT = 3,
  parameter int unsigned SRC_COUNT = 2,
  parameter int unsigned SRC_W     = 1,
  parameter logic [DST_COUNT-1:0]           SECURE_MASK = '0,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] READ_CONN   = '1,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] WRITE_CONN  = '1
) (
  input  logic [SRC_W-1:0]     src,
  input  logic                 is_write,
  input  logic                 nonsecure,
  output logic [DST_COUNT-1:0] allow
);

  for (genvar d = 0; d < DST_COUNT; d++) begin : g_dst
    logic secure_ok;
    logic conn_ok;

    assign secure_ok = !(SECURE_MASK[d] && nonsecure);

    always_comb begin
      conn_ok = 1'b0;
      for (int s = 0; s < SRC_COUNT; s++) begin
        if (int'(src) == s) begin
          conn_ok = is_write ? WRITE_CONN[s + d*SRC_COUNT]
                             : READ_CONN[s + d*SRC_COUNT];
        end
      end
    end

    assign allow[d] = secure_ok && conn_ok;
  end

endmodule

// File: rtl/xdec_priority_pick.sv
module xdec_priority_pick #(
  parameter int unsigned DST_COUNT = 3,
  parameter int unsigned REGIONS   = 2,
  parameter int unsigned DST_W     = 2,
  parameter int unsigned REG_W     = 1
) (
  input  logic [DST_COUNT*REGIONS-1:0] win_hit,
  input  logic [DST_COUNT-1:0]         allow,
  output logic                         any,
  output logic [DST_W-1:0]             dst,
  output logic [REG_W-1:0]             region
);

  // ascending scan, later candidates overwrite earlier ones
  always_comb begin
    any    = 1'b0;
    dst    = '0;
    region = '0;
    for (int d = 0; d < DST_COUNT; d++) begin
      for (int r = 0; r < REGIONS; r++) begin
        if (win_hit[d*REGIONS + r] && allow[d]) begin
          any    = 1'b1;
          dst    = DST_W'(d);
          region = REG_W'(r);
        end
      end
    end
  end

endmodule

// File: rtl/xbar_region_decoder.sv
module xbar_region_decoder #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DST_COUNT = 3,
  parameter int unsigned REGIONS   = 2,
  parameter int unsigned SRC_COUNT = 2,
  parameter logic [DST_COUNT*REGIONS*ADDR_W-1:0] REGION_BASE =
    {32'h0000_1080, 32'h8000_0000, 32'h0000_0000, 32'h0000_1000, 32'h0001_0000, 32'h0000_0000},
  parameter logic [DST_COUNT*REGIONS*8-1:0] REGION_BITS =
    {8'd4, 8'd28, 8'd0, 8'd8, 8'd16, 8'd12},
  parameter logic [DST_COUNT-1:0]           SECURE_MASK = 3'b010,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] READ_CONN   = 6'b011111,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] WRITE_CONN  = 6'b111110,
  localparam int unsigned SRC_W = xdec_pkg::idx_width(SRC_COUNT),
  localparam int unsigned DST_W = xdec_pkg::idx_width(DST_COUNT),
  localparam int unsigned REG_W = xdec_pkg::idx_width(REGIONS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        in_prot,
  input  logic [SRC_W-1:0]  in_src,
  input  logic              in_is_write,
  output logic              out_valid,
  output logic [DST_W-1:0]  out_dst,
  output logic [REG_W-1:0]  out_region,
  output logic              out_hit,
  output logic              out_decerr,
  output logic [1:0]        out_resp
);

  localparam int unsigned WIN_COUNT = DST_COUNT * REGIONS;
  localparam int unsigned SZ_W      = xdec_pkg::SIZE_FIELD_W;

  // window comparators
  logic [WIN_COUNT-1:0] win_hit;

  for (genvar e = 0; e < WIN_COUNT; e++) begin : g_win
    xdec_region_cmp #(
      .ADDR_W (ADDR_W),
      .BASE   (REGION_BASE[e*ADDR_W +: ADDR_W]),
      .BITS   (int'(REGION_BITS[e*SZ_W +: SZ_W]))
    ) u_cmp (
      .addr (in_addr),
      .hit  (win_hit[e])
    );
  end

  // security and connectivity
  logic [DST_COUNT-1:0] allow;

  xdec_access_filter #(
    .DST_COUNT   (DST_COUNT),
    .SRC_COUNT   (SRC_COUNT),
    .SRC_W       (SRC_W),
    .SECURE_MASK (SECURE_MASK),
    .READ_CONN   (READ_CONN),
    .WRITE_CONN  (WRITE_CONN)
  ) u_filter (
    .src       (in_src),
    .is_write  (in_is_write),
    .nonsecure (in_prot[1]),
    .allow     (allow)
  );

  // selection
  logic             pick_any;
  logic [DST_W-1:0] pick_dst;
  logic [REG_W-1:0] pick_region;

  xdec_priority_pick #(
    .DST_COUNT (DST_COUNT),
    .REGIONS   (REGIONS),
    .DST_W     (DST_W),
    .REG_W     (REG_W)
  ) u_pick (
    .win_hit (win_hit),
    .allow   (allow),
    .any     (pick_any),
    .dst     (pick_dst),
    .region  (pick_region)
  );

  // result register: next-state
  logic             valid_q,  valid_d;
  logic             hit_q,    hit_d;
  logic [DST_W-1:0] dst_q,    dst_d;
  logic [REG_W-1:0] region_q, region_d;
  logic             load_en;

  assign load_en = in_valid;

  always_comb begin
    valid_d  = in_valid;
    hit_d    = hit_q;
    dst_d    = dst_q;
    region_d = region_q;
    if (load_en) begin
      hit_d    = pick_any;
      dst_d    = pick_any ? pick_dst    : '0;
      region_d = pick_any ? pick_region : '0;
    end
  end

  // result register: state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      dst_q    <= '0;
      region_q <= '0;
    end else begin
      valid_q  <= valid_d;
      hit_q    <= hit_d;
      dst_q    <= dst_d;
      region_q <= region_d;
    end
  end

  // decode-error flag is held in its own register so reset clears it
  logic err_q, err_d;

  always_comb begin
    err_d = err_q;
    if (load_en) err_d = !pick_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign out_valid  = valid_q;
  assign out_hit    = hit_q;
  assign out_decerr = err_q;
  assign out_dst    = dst_q;
  assign out_region = region_q;
  assign out_resp   = err_q ? xdec_pkg::RESP_DECERR : xdec_pkg::RESP_OKAY;

endmodule

// File: rtl/xdec_checker.sv
module xdec_checker #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DST_COUNT = 3,
  parameter int unsigned REGIONS   = 2,
  parameter int unsigned SRC_COUNT = 2,
  parameter logic [DST_COUNT*REGIONS*ADDR_W-1:0] REGION_BASE = '0,
  parameter logic [DST_COUNT*REGIONS*8-1:0]      REGION_BITS = '0,
  parameter logic [DST_COUNT-1:0]           SECURE_MASK = '0,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] READ_CONN   = '1,
  parameter logic [SRC_COUNT*DST_COUNT-1:0] WRITE_CONN  = '1,
  parameter int unsigned SRC_W = 1,
  parameter int unsigned DST_W = 2,
  parameter int unsigned REG_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic [2:0]        in_prot,
  input logic [SRC_W-1:0]  in_src,
  input logic              in_is_write,
  input logic              out_valid,
  input logic [DST_W-1:0]  out_dst,
  input logic [REG_W-1:0]  out_region,
  input logic              out_hit,
  input logic              out_decerr,
  input logic [1:0]        out_resp
);

  logic [ADDR_W-1:0] q_addr;
  logic [SRC_W-1:0]  q_src;
  logic              q_wr;
  logic              q_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_addr <= '0;
      q_src  <= '0;
      q_wr   <= 1'b0;
      q_ns   <= 1'b0;
    end else if (in_valid) begin
      q_addr <= in_addr;
      q_src  <= in_src;
      q_wr   <= in_is_write;
      q_ns   <= in_prot[1];
    end
  end

  logic [7:0]        sel_bits;
  logic [ADDR_W-1:0] sel_base;
  logic              sel_in_range;
  logic              conn_ok;
  logic              sec_dst;

  always_comb begin
    sel_bits     = '0;
    sel_base     = '0;
    conn_ok      = 1'b0;
    sec_dst      = 1'b0;
    sel_in_range = (int'(out_dst) < DST_COUNT) && (int'(out_region) < REGIONS);
    if (sel_in_range) begin
      sel_bits = REGION_BITS[(int'(out_dst)*REGIONS + int'(out_region))*8 +: 8];
      sel_base = REGION_BASE[(int'(out_dst)*REGIONS + int'(out_region))*ADDR_W +: ADDR_W];
      sec_dst  = SECURE_MASK[out_dst];
      if (int'(q_src) < SRC_COUNT) begin
        conn_ok = q_wr ? WRITE_CONN[int'(q_src) + int'(out_dst)*SRC_COUNT]
                       : READ_CONN[int'(q_src) + int'(out_dst)*SRC_COUNT];
      end
    end
  end

  // R1: the reported window really covers the captured address
  a_r1_window_covers: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> sel_in_range &&
      ((int'(sel_bits) >= ADDR_W) || ((q_addr >> sel_bits) == (sel_base >> sel_bits))));

  // R2: a switched-off window is never reported
  a_r2_no_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> sel_bits != 8'd0);

  // R4: no non-secure access lands on a secure destination
  a_r4_secure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit && q_ns |-> !sec_dst);

  // R5: the selected destination is reachable for this source and direction
  a_r5_connect: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hit |-> conn_ok);

  // R7: exactly one of hit and error, with matching response and zeroed indices
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_hit != out_decerr));
  a_r7_miss_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_decerr |-> (out_resp == 2'b11) && (out_dst == '0) && (out_region == '0));
  a_r7_hit_resp: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_resp == 2'b00);

  // R8: one-cycle latency and hold
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_dst) && $stable(out_region) && $stable(out_hit) && $stable(out_decerr));

endmodule

bind xbar_region_decoder xdec_checker #(
  .ADDR_W      (ADDR_W),
  .DST_COUNT   (DST_COUNT),
  .REGIONS     (REGIONS),
  .SRC_COUNT   (SRC_COUNT),
  .REGION_BASE (REGION_BASE),
  .REGION_BITS (REGION_BITS),
  .SECURE_MASK (SECURE_MASK),
  .READ_CONN   (READ_CONN),
  .WRITE_CONN  (WRITE_CONN),
  .SRC_W       (SRC_W),
  .DST_W       (DST_W),
  .REG_W       (REG_W)
) u_xdec_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_addr     (in_addr),
  .in_prot     (in_prot),
  .in_src      (in_src),
  .in_is_write (in_is_write),
  .out_valid   (out_valid),
  .out_dst     (out_dst),
  .out_region  (out_region),
  .out_hit     (out_hit),
  .out_decerr  (out_decerr),
  .out_resp    (out_resp)
);

// File: tb/xbar_region_decoder_bench.sv
module xbar_region_decoder_bench;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_addr;
  logic [2:0]  in_prot;
  logic [0:0]  in_src;
  logic        in_is_write;
  logic        out_valid;
  logic [1:0]  out_dst;
  logic [0:0]  out_region;
  logic        out_hit;
  logic        out_decerr;
  logic [1:0]  out_resp;

  int checks;
  int failures;
  bit finished;

  xbar_region_decoder u_xbar_region_decoder (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_addr     (in_addr),
    .in_prot     (in_prot),
    .in_src      (in_src),
    .in_is_write (in_is_write),
    .out_valid   (out_valid),
    .out_dst     (out_dst),
    .out_region  (out_region),
    .out_hit     (out_hit),
    .out_decerr  (out_decerr),
    .out_resp    (out_resp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // one decode, result sampled on the falling edge after the capturing edge
  task automatic decode(input string req, input logic src, input logic wr,
                        input logic [2:0] prot, input logic [31:0] addr,
                        input bit exp_hit, input logic [1:0] exp_dst,
                        input logic exp_reg);
    logic [1:0] exp_d;
    logic       exp_r;
    exp_d = exp_hit ? exp_dst : 2'd0;
    exp_r = exp_hit ? exp_reg : 1'b0;
    @(negedge clk);
    in_valid    = 1'b1;
    in_addr     = addr;
    in_prot     = prot;
    in_src      = src;
    in_is_write = wr;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R8", "out_valid", 32'(out_valid), 32'd1);
    check(out_hit == exp_hit, req, "out_hit", 32'(out_hit), 32'(exp_hit));
    check(out_decerr == !exp_hit, "R7", "out_decerr", 32'(out_decerr), 32'(!exp_hit));
    check(out_resp == (exp_hit ? 2'b00 : 2'b11), "R7", "out_resp",
          32'(out_resp), exp_hit ? 32'd0 : 32'd3);
    check(out_dst == exp_d, req, "out_dst", 32'(out_dst), 32'(exp_d));
    check(out_region == exp_r, req, "out_region", 32'(out_region), 32'(exp_r));
  endtask

  task automatic t_reset;
    check(out_valid == 0 && out_hit == 0 && out_decerr == 0 && out_dst == 0 &&
          out_region == 0 && out_resp == 0, "R9", "outputs in reset",
          {out_valid, out_hit, out_decerr, out_dst, out_region, out_resp}, 32'd0);
  endtask

  task automatic t_basic_match;
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h0000_0ABC, 1, 2'd0, 1'b0);
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h0000_0FFF, 1, 2'd0, 1'b0);
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h0001_2345, 1, 2'd0, 1'b1);
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h0001_FFFF, 1, 2'd0, 1'b1);
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h8123_4567, 1, 2'd2, 1'b0);
    decode("R1", 1'b0, 1'b0, 3'b000, 32'h0002_0000, 0, 2'd0, 1'b0);
  endtask

  task automatic t_disabled_window;
    // dst1 window1 has size 0 and base 0; address 0 must fall to dst0 window0
    decode("R2", 1'b0, 1'b0, 3'b000, 32'h0000_0000, 1, 2'd0, 1'b0);
  endtask

  task automatic t_small_windows;
    decode("R3", 1'b0, 1'b0, 3'b000, 32'h0000_1000, 1, 2'd1, 1'b0);
    decode("R3", 1'b0, 1'b0, 3'b000, 32'h0000_10FF, 1, 2'd1, 1'b0);
    decode("R3", 1'b0, 1'b0, 3'b000, 32'h0000_1100, 0, 2'd0, 1'b0);
    decode("R3", 1'b0, 1'b0, 3'b000, 32'h0000_1090, 1, 2'd1, 1'b0);
    decode("R3", 1'b0, 1'b0, 3'b000, 32'h0000_107F, 1, 2'd1, 1'b0);
  endtask

  task automatic t_secure;
    decode("R4", 1'b0, 1'b0, 3'b010, 32'h0000_1050, 0, 2'd0, 1'b0);
    decode("R4", 1'b0, 1'b0, 3'b101, 32'h0000_1050, 1, 2'd1, 1'b0);
    decode("R4", 1'b0, 1'b0, 3'b010, 32'h0000_0ABC, 1, 2'd0, 1'b0);
  endtask

  task automatic t_connectivity;
    decode("R5", 1'b1, 1'b0, 3'b000, 32'h8000_0000, 0, 2'd0, 1'b0);
    decode("R5", 1'b1, 1'b1, 3'b000, 32'h8000_0000, 1, 2'd2, 1'b0);
    decode("R5", 1'b0, 1'b1, 3'b000, 32'h0000_0ABC, 0, 2'd0, 1'b0);
    decode("R5", 1'b1, 1'b1, 3'b000, 32'h0000_0ABC, 1, 2'd0, 1'b0);
  endtask

  task automatic t_priority;
    decode("R6", 1'b0, 1'b0, 3'b000, 32'h0000_1085, 1, 2'd2, 1'b1);
    decode("R6", 1'b0, 1'b0, 3'b010, 32'h0000_108F, 1, 2'd2, 1'b1);
    // source 1 may not read dst2, so the overlapped dst1 window takes it
    decode("R6", 1'b1, 1'b0, 3'b000, 32'h0000_1085, 1, 2'd1, 1'b0);
  endtask

  task automatic t_hold;
    decode("R8", 1'b0, 1'b0, 3'b000, 32'h0001_0004, 1, 2'd0, 1'b1);
    in_addr = 32'h0000_2000;
    in_src  = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid idle", 32'(out_valid), 32'd0);
    check(out_hit == 1'b1 && out_dst == 2'd0 && out_region == 1'b1, "R8",
          "held result", {out_hit, out_dst, out_region}, {1'b1, 2'd0, 1'b1});
    decode("R7", 1'b0, 1'b0, 3'b000, 32'h0000_2000, 0, 2'd0, 1'b0);
    @(negedge clk);
    check(out_decerr == 1'b1 && out_resp == 2'b11, "R7", "held error",
          {out_decerr, out_resp}, {1'b1, 2'b11});
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks      = 0;
    failures    = 0;
    finished    = 1'b0;
    rst_n       = 1'b0;
    in_valid    = 1'b0;
    in_addr     = '0;
    in_prot     = '0;
    in_src      = '0;
    in_is_write = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic_match();
    t_disabled_window();
    t_small_windows();
    t_secure();
    t_connectivity();
    t_priority();
    t_hold();
    finish_run();
  end

endmodule